// File: doc/BRIEF.md
# Configuration Header Register File

This block holds the 64-byte header at the bottom of a 4 KiB configuration space for an endpoint or bridge function. Software sees 1024 dword registers. Every index answers a full-dword read one cycle after the index is presented. Writes arrive one per cycle and may be one, two or four bytes wide. Each register has a fixed writable-bit mask, and a write can only change bits that its lanes cover and its mask allows. The rest of the register stays as it was. The identification words are loaded from parameters at reset. A parameter picks the header kind, either a plain function or a bridge, and that choice decides both the header-type field and which bits are writable.

A side strobe lets the surrounding logic load the interrupt line and pin into the interrupt register. This path ignores the software write mask. Only the first 16 dwords are backed by flops. All other in-range indices read zero, and an index at or above the space size reads all ones.

Top module: `cfg_hdr_regfile`

## Requirements
- R1: While reset is held the read data is 0. After reset, dword 0 reads {device id, vendor id}, dword 2 reads {class, subclass, programming interface (default 0), revision}, and dword 11 reads {subsystem id, subsystem vendor id}. Dword 3 reads 0x00000000 for a plain function and 0x00010000 for a bridge.
- R2: rdData shows the register selected by rdIdx at the following clock edge. Indices 16 to NUM_REGS-1 read 0, and an index of NUM_REGS or more reads 0xFFFFFFFF.
- R3: In dword 1, bits 15:0 (command) are writable and bits 31:16 (status) ignore all writes.
- R4: In dword 3, only bits 7:0 are writable. The header-type field in bits 23:16 keeps its reset value.
- R5: A plain function has writable mask 0x000000FF on dword 15 and no writable bits in dword 9. A bridge has mask 0xFFF0FFF0 on dword 9 and 0xFFFF00FF on dword 15.
- R6: wrSize 1 writes a byte, 2 a word and 4 a dword. wrData is right-aligned and is moved to bit offset 8*wrOff. For every width, each stored bit becomes (old & ~m) | (new & m), where m is the byte-lane mask ANDed with the register's writable mask.
- R7: A word write with wrOff 1 or 3 is dropped.
- R8: A write is dropped if wrOff plus its length is more than 4 bytes, or if wrSize is not 1, 2 or 4.
- R9: An irqSet cycle loads dword 15 with {bits 31:16 unchanged, irqPin+1, irqLine}. irqPin 0 stands for pin A and gives 1. This load ignores the write mask.
- R10: A write to dword 15 in the same cycle as irqSet is dropped.
- R11: A read in the same cycle as a write to the same dword returns the contents from before that write.
- R12: Writes to dwords that have no writable bits change nothing. This covers identification dwords and indices from 16 up to the end of the space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Write strobe, one write per cycle |
| wrIdx | input | IDX_W | Dword index of the write |
| wrOff | input | 2 | Byte offset within the dword |
| wrSize | input | 3 | Write length in bytes (1, 2 or 4) |
| wrData | input | 32 | Right-aligned write value |
| irqSet | input | 1 | Load interrupt line and pin into dword 15 |
| irqLine | input | 8 | Interrupt line number |
| irqPin | input | 2 | Interrupt pin, 0 = A to 3 = D |
| rdIdx | input | IDX_W | Dword index to read |
| rdData | output | 32 | Registered read data |

## Verification
The same stimulus drives a plain-function instance and a bridge instance, so every write pattern separates the two mask layouts. Full-dword writes of all ones show the complete writable mask of each register. Byte writes at each of the four offsets show that the lane shift is correct and that only one lane changes. Word writes at the aligned offsets, the misaligned offsets and the over-length shapes show which writes are accepted. The tests also cover an interrupt load with and without a colliding write, a read in the same cycle as a write, and reads at the edges of the backed, zero and out-of-range index regions. Together these show that a write merges its bits into the register and does not overwrite the whole dword.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  // Header dword positions that software and neighbouring logic decode
  localparam int REG_ID     = 0;
  localparam int REG_CMD    = 1;
  localparam int REG_CLASS  = 2;
  localparam int REG_MISC   = 3;
  localparam int REG_BRWIN  = 9;
  localparam int REG_SUBSYS = 11;
  localparam int REG_INTR   = 15;

  // Strobes from the write-decode control to the storage datapath
  typedef struct packed {
    logic        wrEn;
    logic        irqEn;
    logic [31:0] laneMask;
    logic [31:0] wrWord;
    logic [15:0] irqWord;
  } cfgStrobe_t;

  function automatic logic [31:0] hdrWmask(input int idx, input bit bridge);
    case (idx)
      REG_CMD:   return 32'h0000_FFFF;
      REG_MISC:  return 32'h0000_00FF;
      REG_BRWIN: return bridge ? 32'hFFF0_FFF0 : 32'h0000_0000;
      REG_INTR:  return bridge ? 32'hFFFF_00FF : 32'h0000_00FF;
      default:   return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [31:0] hdrReset(
    input int          idx,
    input bit          bridge,
    input logic [15:0] venId,
    input logic [15:0] devId,
    input logic [15:0] subVen,
    input logic [15:0] subId,
    input logic [7:0]  cls,
    input logic [7:0]  sub,
    input logic [7:0]  pif,
    input logic [7:0]  rev
  );
    case (idx)
      REG_ID:     return {devId, venId};
      REG_CLASS:  return {cls, sub, pif, rev};
      REG_MISC:   return bridge ? 32'h0001_0000 : 32'h0000_0000;
      REG_SUBSYS: return {subId, subVen};
      default:    return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/cfg_hdr_ctrl.sv
module cfg_hdr_ctrl
  import cfg_hdr_pkg::*;
#(
  parameter int IDX_W      = 11,
  parameter int SIDX_W     = 4,
  parameter int STORE_REGS = 16
) (
  input  logic              wrValid,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [1:0]        wrOff,
  input  logic [2:0]        wrSize,
  input  logic [31:0]       wrData,
  input  logic              irqSet,
  input  logic [7:0]        irqLine,
  input  logic [1:0]        irqPin,
  output cfgStrobe_t        strb,
  output logic [SIDX_W-1:0] wrSel
);

  localparam logic [IDX_W-1:0] STORE_LIM = IDX_W'(STORE_REGS);
  localparam logic [IDX_W-1:0] INTR_IDX  = IDX_W'(REG_INTR);

  logic       shapeOk;
  logic       hit;
  logic       collide;
  logic [4:0] shift;

  always_comb begin
    shift = {wrOff, 3'b000};

    // Legal length/offset combinations
    case (wrSize)
      3'd1:    shapeOk = 1'b1;
      3'd2:    shapeOk = !wrOff[0];
      3'd4:    shapeOk = (wrOff == 2'd0);
      default: shapeOk = 1'b0;
    endcase

    case (wrSize)
      3'd1:    strb.laneMask = 32'h0000_00FF << shift;
      3'd2:    strb.laneMask = 32'h0000_FFFF << shift;
      default: strb.laneMask = 32'hFFFF_FFFF;
    endcase

    hit     = (wrIdx < STORE_LIM);
    collide = irqSet && (wrIdx == INTR_IDX);

    strb.wrEn    = wrValid && shapeOk && hit && !collide;
    strb.irqEn   = irqSet;
    strb.wrWord  = wrData << shift;
    strb.irqWord = {({6'b0, irqPin} + 8'd1), irqLine};
  end

  assign wrSel = wrIdx[SIDX_W-1:0];

endmodule

// File: rtl/cfg_hdr_dpath.sv
module cfg_hdr_dpath
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'h0000,
  parameter logic [15:0] DEVICE_ID     = 16'h0000,
  parameter logic [7:0]  REVISION      = 8'h00,
  parameter logic [7:0]  CLASS_CODE    = 8'h00,
  parameter logic [7:0]  SUBCLASS      = 8'h00,
  parameter logic [7:0]  PROG_IF       = 8'h00,
  parameter logic [15:0] SUBSYS_VENDOR = 16'h0000,
  parameter logic [15:0] SUBSYS_ID     = 16'h0000,
  parameter bit          IS_BRIDGE     = 1'b0,
  parameter int          IDX_W         = 11,
  parameter int          SIDX_W        = 4,
  parameter int          STORE_REGS    = 16,
  parameter int          NUM_REGS      = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strb,
  input  logic [SIDX_W-1:0] wrSel,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [31:0]       rdData
);

  localparam logic [IDX_W-1:0] STORE_LIM = IDX_W'(STORE_REGS);
  localparam logic [IDX_W-1:0] NUM_LIM   = IDX_W'(NUM_REGS);

  logic [31:0] regVal [STORE_REGS];

  for (genvar g = 0; g < STORE_REGS; g++) begin : g_reg
    localparam logic [31:0] WMASK = hdrWmask(g, IS_BRIDGE);
    localparam logic [31:0] RSTV  = hdrReset(g, IS_BRIDGE, VENDOR_ID, DEVICE_ID,
                                             SUBSYS_VENDOR, SUBSYS_ID, CLASS_CODE,
                                             SUBCLASS, PROG_IF, REVISION);
    logic [31:0] q;
    logic [31:0] eff;

    assign eff = strb.laneMask & WMASK;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q <= RSTV;
      end else if (strb.irqEn && (g == REG_INTR)) begin
        q <= {q[31:16], strb.irqWord};
      end else if (strb.wrEn && (wrSel == SIDX_W'(g))) begin
        q <= (q & ~eff) | (strb.wrWord & eff);
      end
    end

    assign regVal[g] = q;
  end

  // Registered read port: backed header, zero region, out-of-range
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (rdIdx < STORE_LIM) begin
      rdData <= regVal[rdIdx[SIDX_W-1:0]];
    end else if (rdIdx < NUM_LIM) begin
      rdData <= '0;
    end else begin
      rdData <= '1;
    end
  end

endmodule

// File: rtl/cfg_hdr_regfile.sv
module cfg_hdr_regfile
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID     = 16'h5A17,
  parameter logic [7:0]  REVISION      = 8'h03,
  parameter logic [7:0]  CLASS_CODE    = 8'h02,
  parameter logic [7:0]  SUBCLASS      = 8'h80,
  parameter logic [7:0]  PROG_IF       = 8'h00,
  parameter logic [15:0] SUBSYS_VENDOR = 16'h1357,
  parameter logic [15:0] SUBSYS_ID     = 16'h2468,
  parameter bit          IS_BRIDGE     = 1'b0,
  parameter int          NUM_REGS      = 1024,
  parameter int          STORE_REGS    = 16,
  localparam int         IDX_W         = $clog2(NUM_REGS) + 1,
  localparam int         SIDX_W        = $clog2(STORE_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [1:0]       wrOff,
  input  logic [2:0]       wrSize,
  input  logic [31:0]      wrData,
  input  logic             irqSet,
  input  logic [7:0]       irqLine,
  input  logic [1:0]       irqPin,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [31:0]      rdData
);

  cfgStrobe_t        strb;
  logic [SIDX_W-1:0] wrSel;

  cfg_hdr_ctrl #(
    .IDX_W     (IDX_W),
    .SIDX_W    (SIDX_W),
    .STORE_REGS(STORE_REGS)
  ) u_ctrl (
    .wrValid(wrValid),
    .wrIdx  (wrIdx),
    .wrOff  (wrOff),
    .wrSize (wrSize),
    .wrData (wrData),
    .irqSet (irqSet),
    .irqLine(irqLine),
    .irqPin (irqPin),
    .strb   (strb),
    .wrSel  (wrSel)
  );

  cfg_hdr_dpath #(
    .VENDOR_ID    (VENDOR_ID),
    .DEVICE_ID    (DEVICE_ID),
    .REVISION     (REVISION),
    .CLASS_CODE   (CLASS_CODE),
    .SUBCLASS     (SUBCLASS),
    .PROG_IF      (PROG_IF),
    .SUBSYS_VENDOR(SUBSYS_VENDOR),
    .SUBSYS_ID    (SUBSYS_ID),
    .IS_BRIDGE    (IS_BRIDGE),
    .IDX_W        (IDX_W),
    .SIDX_W       (SIDX_W),
    .STORE_REGS   (STORE_REGS),
    .NUM_REGS     (NUM_REGS)
  ) u_dpath (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wrSel (wrSel),
    .rdIdx (rdIdx),
    .rdData(rdData)
  );

endmodule

// File: rtl/cfg_hdr_regfile_chk.sv
module cfg_hdr_regfile_chk
  import cfg_hdr_pkg::*;
#(
  parameter int          IDX_W    = 11,
  parameter int          NUM_REGS = 1024,
  parameter logic [31:0] ID_WORD  = 32'h0
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrValid,
  input logic [IDX_W-1:0] wrIdx,
  input logic [1:0]       wrOff,
  input logic [2:0]       wrSize,
  input logic             irqSet,
  input logic [IDX_W-1:0] rdIdx,
  input logic [31:0]      rdData,
  input cfgStrobe_t       strb
);

  localparam logic [IDX_W-1:0] NUM_LIM  = IDX_W'(NUM_REGS);
  localparam logic [IDX_W-1:0] INTR_IDX = IDX_W'(REG_INTR);

  p_dword_offset_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrSize == 3'd4 && wrOff != 2'd0) |-> !strb.wrEn);

  p_word_align_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrSize == 3'd2 && wrOff[0]) |-> !strb.wrEn);

  p_lane_width_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> ($countones(strb.laneMask) == 8 ||
                   $countones(strb.laneMask) == 16 ||
                   $countones(strb.laneMask) == 32));

  p_irq_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irqSet && wrIdx == INTR_IDX) |-> !strb.wrEn);

  p_oob_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx >= NUM_LIM) |=> (rdData == 32'hFFFF_FFFF));

  p_id_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx == '0) |=> (rdData == ID_WORD));

endmodule

bind cfg_hdr_regfile cfg_hdr_regfile_chk #(
  .IDX_W   (IDX_W),
  .NUM_REGS(NUM_REGS),
  .ID_WORD ({DEVICE_ID, VENDOR_ID})
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrValid(wrValid),
  .wrIdx  (wrIdx),
  .wrOff  (wrOff),
  .wrSize (wrSize),
  .irqSet (irqSet),
  .rdIdx  (rdIdx),
  .rdData (rdData),
  .strb   (strb)
);

// File: tb/test_cfg_hdr_regfile.sv
`timescale 1ns/1ps
module test_cfg_hdr_regfile;

  localparam logic [15:0] VEN = 16'hC0DE;
  localparam logic [15:0] DEV = 16'h5A17;
  localparam logic [7:0]  REV = 8'h03;
  localparam logic [7:0]  CLS = 8'h02;
  localparam logic [7:0]  SUB = 8'h80;
  localparam logic [15:0] SSV = 16'h1357;
  localparam logic [15:0] SSI = 16'h2468;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [10:0] wrIdx = '0;
  logic [1:0]  wrOff = '0;
  logic [2:0]  wrSize = '0;
  logic [31:0] wrData = '0;
  logic        irqSet = 1'b0;
  logic [7:0]  irqLine = '0;
  logic [1:0]  irqPin = '0;
  logic [10:0] rdIdx = '0;
  logic [31:0] rdDev, rdBrg;

  always #4 clk = ~clk;

  cfg_hdr_regfile #(.VENDOR_ID(VEN), .DEVICE_ID(DEV), .REVISION(REV), .CLASS_CODE(CLS),
                    .SUBCLASS(SUB), .SUBSYS_VENDOR(SSV), .SUBSYS_ID(SSI), .IS_BRIDGE(1'b0))
  i_cfg_hdr_regfile (.clk(clk), .rstN(rstN), .wrValid(wrValid), .wrIdx(wrIdx), .wrOff(wrOff),
                     .wrSize(wrSize), .wrData(wrData), .irqSet(irqSet), .irqLine(irqLine),
                     .irqPin(irqPin), .rdIdx(rdIdx), .rdData(rdDev));

  cfg_hdr_regfile #(.VENDOR_ID(VEN), .DEVICE_ID(DEV), .REVISION(REV), .CLASS_CODE(CLS),
                    .SUBCLASS(SUB), .SUBSYS_VENDOR(SSV), .SUBSYS_ID(SSI), .IS_BRIDGE(1'b1))
  i_cfg_hdr_regfile_brg (.clk(clk), .rstN(rstN), .wrValid(wrValid), .wrIdx(wrIdx), .wrOff(wrOff),
                         .wrSize(wrSize), .wrData(wrData), .irqSet(irqSet), .irqLine(irqLine),
                         .irqPin(irqPin), .rdIdx(rdIdx), .rdData(rdBrg));

  typedef struct {
    logic [31:0] e0;
    logic [31:0] e1;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  int          nTests = 0;
  int          nFail = 0;
  bit          done = 1'b0;
  logic        rdReq = 1'b0;
  logic        rdReqQ = 1'b0;
  logic [31:0] mdl [2][16];

  // Writable masks per R3, R4, R5
  function automatic logic [31:0] maskOf(input int b, input int i);
    case (i)
      1:       return 32'h0000_FFFF;
      3:       return 32'h0000_00FF;
      9:       return (b == 1) ? 32'hFFF0_FFF0 : 32'h0;
      15:      return (b == 1) ? 32'hFFFF_00FF : 32'h0000_00FF;
      default: return 32'h0;
    endcase
  endfunction

  // Reset contents per R1
  function automatic logic [31:0] rstOf(input int b, input int i);
    case (i)
      0:       return {DEV, VEN};
      2:       return {CLS, SUB, 8'h00, REV};
      3:       return (b == 1) ? 32'h0001_0000 : 32'h0;
      11:      return {SSI, SSV};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] mdlRead(input int b, input int i);
    if (i < 16) return mdl[b][i];
    if (i < 1024) return 32'h0;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic step(input bit wv, input int wi, input int wo, input int ws,
                      input logic [31:0] wd, input bit rv, input int ri,
                      input bit iv, input logic [7:0] il, input logic [1:0] ip,
                      input string tag);
    exp_t e;
    bit ok;
    logic [31:0] lane, m;
    @(negedge clk);
    wrValid = wv; wrIdx = 11'(wi); wrOff = 2'(wo); wrSize = 3'(ws); wrData = wd;
    irqSet = iv; irqLine = il; irqPin = ip;
    rdReq = rv; rdIdx = 11'(ri);
    if (rv) begin
      e.e0 = mdlRead(0, ri); e.e1 = mdlRead(1, ri); e.tag = tag;
      expQ.push_back(e);
    end
    ok = wv && ((ws == 1) || (ws == 2 && (wo == 0 || wo == 2)) || (ws == 4 && wo == 0));
    if (iv && wi == 15) ok = 1'b0;
    if (ok && wi < 16) begin
      lane = (ws == 4) ? 32'hFFFF_FFFF :
             (ws == 2) ? (32'h0000_FFFF << (wo * 8)) : (32'h0000_00FF << (wo * 8));
      for (int b = 0; b < 2; b++) begin
        m = lane & maskOf(b, wi);
        mdl[b][wi] = (mdl[b][wi] & ~m) | ((wd << (wo * 8)) & m);
      end
    end
    if (iv) begin
      for (int b = 0; b < 2; b++)
        mdl[b][15] = {mdl[b][15][31:16], 8'({6'b0, ip}) + 8'd1, il};
    end
  endtask

  task automatic wr(input int wi, input int wo, input int ws, input logic [31:0] wd);
    step(1'b1, wi, wo, ws, wd, 1'b0, 0, 1'b0, 8'h0, 2'd0, "");
  endtask

  task automatic rd(input int ri, input string tag);
    step(1'b0, 0, 0, 0, 32'h0, 1'b1, ri, 1'b0, 8'h0, 2'd0, tag);
  endtask

  always @(posedge clk) rdReqQ <= rdReq;

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rdReqQ) begin
      if (expQ.size() == 0) begin
        nFail++;
        $display("FAIL scoreboard: read result with no expected item, act %h/%h exp none", rdDev, rdBrg);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        nTests += 2;
        if (rdDev !== e.e0) begin
          nFail++;
          $display("FAIL %s device: act %h exp %h", e.tag, rdDev, e.e0);
        end
        if (rdBrg !== e.e1) begin
          nFail++;
          $display("FAIL %s bridge: act %h exp %h", e.tag, rdBrg, e.e1);
        end
      end
    end
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 16; i++) mdl[b][i] = rstOf(b, i);
    repeat (3) @(negedge clk);
    nTests++;
    if (rdDev !== 32'h0 || rdBrg !== 32'h0) begin
      nFail++;
      $display("FAIL R1 reset rdData: act %h/%h exp 00000000", rdDev, rdBrg);
    end
    rstN = 1'b1;

    // R1 identification after reset
    rd(0, "R1"); rd(2, "R1"); rd(3, "R1"); rd(11, "R1"); rd(15, "R1"); rd(9, "R1");
    // R2 index regions
    rd(16, "R2"); rd(1023, "R2"); rd(1024, "R2"); rd(2047, "R2");
    // R3 command writable, status read-only
    wr(1, 0, 4, 32'hFFFF_FFFF); rd(1, "R3");
    wr(1, 2, 2, 32'h0000_ABCD); rd(1, "R3");
    // R4 cache line field only
    wr(3, 0, 4, 32'hFFFF_FFFF); rd(3, "R4");
    wr(3, 2, 1, 32'h0000_0077); rd(3, "R4");
    // R5 header-kind masks
    wr(9, 0, 4, 32'hFFFF_FFFF); rd(9, "R5");
    wr(15, 0, 4, 32'hFFFF_FFFF); rd(15, "R5");
    wr(15, 0, 4, 32'h0000_0000); rd(15, "R5");
    // R6 byte writes at each offset
    wr(15, 0, 1, 32'h0000_0011); rd(15, "R6");
    wr(15, 1, 1, 32'h0000_0022); rd(15, "R6");
    wr(15, 2, 1, 32'h0000_0033); rd(15, "R6");
    wr(15, 3, 1, 32'h0000_0044); rd(15, "R6");
    wr(1, 1, 1, 32'hFFFF_FF5A); rd(1, "R6");
    wr(9, 2, 2, 32'h0000_1234); rd(9, "R6");
    // R7 misaligned word writes
    wr(1, 1, 2, 32'h0000_0000); rd(1, "R7");
    wr(15, 3, 2, 32'h0000_0000); rd(15, "R7");
    // R8 over-length and bad sizes
    wr(1, 2, 4, 32'h0000_0000); rd(1, "R8");
    wr(1, 0, 3, 32'h0000_0000); rd(1, "R8");
    wr(1, 0, 0, 32'h0000_0000); rd(1, "R8");
    wr(1, 1, 7, 32'h0000_0000); rd(1, "R8");
    // R9 interrupt load
    step(1'b0, 0, 0, 0, 32'h0, 1'b0, 0, 1'b1, 8'h2B, 2'd0, ""); rd(15, "R9");
    step(1'b0, 0, 0, 0, 32'h0, 1'b0, 0, 1'b1, 8'hE1, 2'd3, ""); rd(15, "R9");
    // R10 colliding write dropped; write to another dword still lands
    step(1'b1, 15, 0, 4, 32'h5555_AAAA, 1'b0, 0, 1'b1, 8'h07, 2'd1, ""); rd(15, "R10");
    step(1'b1, 3, 0, 1, 32'h0000_0042, 1'b0, 0, 1'b1, 8'h08, 2'd2, "");
    rd(3, "R10"); rd(15, "R10");
    // R11 read during write sees old contents
    step(1'b1, 1, 0, 4, 32'h0000_9876, 1'b1, 1, 1'b0, 8'h0, 2'd0, "R11");
    rd(1, "R11");
    // R12 writes to read-only dwords
    wr(0, 0, 4, 32'h1111_1111); rd(0, "R12");
    wr(2, 1, 2, 32'h0000_FFFF); rd(2, "R12");
    wr(11, 3, 1, 32'h0000_00EE); rd(11, "R12");
    wr(20, 0, 4, 32'hFFFF_FFFF); rd(20, "R12");
    wr(1030, 0, 4, 32'hFFFF_FFFF); rd(1030, "R12");
    wr(4, 0, 4, 32'hFFFF_FFFF); rd(4, "R12");

    step(1'b0, 0, 0, 0, 32'h0, 1'b0, 0, 1'b0, 8'h0, 2'd0, "");
    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      nFail++;
      $display("FAIL scoreboard: %0d results missing, exp 0", expQ.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nTests++;
      nFail++;
      $display("FAIL watchdog: run did not end, act timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule